// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block is the decision core of a protector for a battery pack built from two cells in series. Analog comparators outside the block turn cell and pack voltages, charger and load sensing, the current-sense trip and the centre-tap continuity check into single-bit flags. The block turns those flags into three kinds of output:

- an enable for the series disconnect switch;
- a bleed enable for each cell;
- a low-power sleep indication.

Apart from the short-circuit trip, every decision is taken on a slow periodic tick, nominally 4 ms. A short-circuit trip acts on the very next clock. The priority between conditions, from highest to lowest, is: short circuit, lost centre tap, pack undervoltage, over-discharge, overcharge, normal.

The block has two duty-cycled recovery modes, both built on a frame of 2^FRAME_W ticks (8 ticks by default). Slot 0 is the first tick of the frame and the last slot is the final tick:

- **Over-discharge with a charger:** the switch is off only in the last slot.
- **Pack undervoltage with a charger:** the switch is on only in slot 0.

In both modes the charger flag is looked at only in the last slot of the frame.

An overcharge seen while a charger is present must last for three consecutive ticks before it counts. The switch then stays closed for a programmable grace period. After that it opens, and only the overcharged cells are bled.

Top module: `pack_guard`

## Requirements
- R1: While reset is held and right after it is released, the switch is off, both bleeds are off and sleep is asserted.
- R2: A short-circuit flag on any clock turns the switch off on the following clock. The block then stays in a tripped state with the switch off until a tick sees the load flag low and the short flag low. On that tick, normal classification takes over.
- R3: A tick that sees the centre-tap-lost flag turns the switch off. The exception is when pack undervoltage and a charger are both present: the block then enters the 1-in-8 recovery frame.
- R4: A tick with pack undervoltage and a charger present starts the 1-in-8 frame at slot 0. In this frame the switch is on in slot 0 only. A tick with pack undervoltage and no charger present enters sleep.
- R5: A tick with either cell over-discharged, a charger present, and no higher-priority condition starts the 7-in-8 frame at slot 0. In this frame the switch is on in slots 0 to 6 and off in slot 7.
- R6: Within either recovery frame, the charger flag is ignored on every tick except the one that ends the last slot. If the charger is absent on that tick, the block leaves the frame and enters sleep with the switch off.
- R7: A tick with either cell over-discharged, no charger present, and no higher-priority condition puts the block in sleep with the switch off.
- R8: Once in sleep, the block stays there on every tick without a charger, whatever the other flags are. It leaves sleep only on a tick that sees the charger, or on a short-circuit flag.
- R9: An overcharge on either cell while a charger is present qualifies only on the third consecutive tick that sees it. Until it qualifies, the switch stays on.
- R10: After qualification, the switch stays on for exactly grace_len further ticks and then opens. A grace_len of 0 opens the switch on the qualifying tick itself.
- R11: While the switch is held open for overcharge, each bleed output follows its own cell's overcharge flag. Neither bleed is ever on while the switch is on.
- R12: An overcharged cell with no charger present sets the switch to follow the load flag: on with a load, off without one.
- R13: With no fault, the switch is on. Between ticks, no flag other than the short-circuit flag changes the switch or sleep outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock pulse marking each decision instant |
| cell_hi_over | input | 1 | Upper cell is above the overcharge level |
| cell_lo_over | input | 1 | Lower cell is above the overcharge level |
| cell_hi_under | input | 1 | Upper cell is below the over-discharge level |
| cell_lo_under | input | 1 | Lower cell is below the over-discharge level |
| pack_low | input | 1 | Whole pack is below the undervoltage level |
| charger_on | input | 1 | Charger detected |
| load_on | input | 1 | Load detected |
| short_hit | input | 1 | Current-sense trip |
| tap_lost | input | 1 | Centre-tap connection is open |
| grace_len | input | GRACE_W | Grace ticks after an overcharge qualifies |
| switch_on | output | 1 | Disconnect switch enable |
| bleed_hi | output | 1 | Bleed enable for the upper cell |
| bleed_lo | output | 1 | Bleed enable for the lower cell |
| sleep_mode | output | 1 | Low-power shutdown indication |

## Verification
Some properties hold from one clock to the next, and the assertions check these on every cycle:

- a short-circuit flag opens the switch one clock later;
- the switch and sleep outputs never move between ticks unless a short arrives;
- a bleed never coexists with a closed switch;
- sleep never coexists with a closed switch, and is kept while no charger is present;
- a lost centre tap without the undervoltage exception opens the switch.

The remaining behaviour depends on history and can only be shown by the bench's scenarios: the three-tick overcharge qualification, the exact length of the grace period, the on and off slots inside each recovery frame, and the charger check being made only in the final slot. The same holds for release from a trip only after the load goes away, and for the block's behaviour when several faults of different priority overlap.

// File: rtl/pack_guard.sv
module pack_guard #(
  parameter int GRACE_W = 16,
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cell_hi_over,
  input  logic               cell_lo_over,
  input  logic               cell_hi_under,
  input  logic               cell_lo_under,
  input  logic               pack_low,
  input  logic               charger_on,
  input  logic               load_on,
  input  logic               short_hit,
  input  logic               tap_lost,
  input  logic [GRACE_W-1:0] grace_len,
  output logic               switch_on,
  output logic               bleed_hi,
  output logic               bleed_lo,
  output logic               sleep_mode
);

  localparam logic [FRAME_W-1:0] LAST_SLOT  = '1;
  localparam logic [FRAME_W-1:0] FIRST_SLOT = '0;

  typedef enum logic [2:0] {
    ST_SLEEP, ST_RUN, ST_OPEN, ST_GRACE, ST_HOLD, ST_TRIP, ST_CYC_HI, ST_CYC_LO
  } st_t;

  st_t                st, st_nx, cls;
  logic [FRAME_W-1:0] slot, slot_nx;
  logic [GRACE_W-1:0] gcnt, gcnt_nx;
  logic [1:0]         oc_run;

  wire any_over  = cell_hi_over | cell_lo_over;
  wire any_under = cell_hi_under | cell_lo_under;
  wire cycling   = (st == ST_CYC_HI) || (st == ST_CYC_LO);
  wire chg_eff   = (cycling && slot != LAST_SLOT) ? 1'b1 : charger_on;
  wire oc_ok     = any_over && charger_on && (oc_run >= 2'd2);

  always_comb begin
    cls     = ST_RUN;
    gcnt_nx = gcnt;
    if (tap_lost)
      cls = (pack_low && chg_eff) ? ST_CYC_LO : ST_OPEN;
    else if (pack_low)
      cls = chg_eff ? ST_CYC_LO : ST_SLEEP;
    else if (any_under)
      cls = chg_eff ? ST_CYC_HI : ST_SLEEP;
    else if (any_over) begin
      if (!chg_eff)
        cls = load_on ? ST_RUN : ST_OPEN;
      else if (st == ST_HOLD)
        cls = ST_HOLD;
      else if (st == ST_GRACE) begin
        if (gcnt == '0) cls = ST_HOLD;
        else begin
          cls     = ST_GRACE;
          gcnt_nx = gcnt - 1'b1;
        end
      end else if (oc_ok) begin
        if (grace_len == '0) cls = ST_HOLD;
        else begin
          cls     = ST_GRACE;
          gcnt_nx = grace_len - 1'b1;
        end
      end else
        cls = ST_RUN;
    end
  end

  always_comb begin
    st_nx = st;
    if (short_hit)
      st_nx = ST_TRIP;
    else if (tick) begin
      if (st == ST_TRIP)
        st_nx = load_on ? ST_TRIP : cls;
      else if (st == ST_SLEEP && !charger_on)
        st_nx = ST_SLEEP;
      else
        st_nx = cls;
    end
  end

  always_comb begin
    if (st_nx != st)         slot_nx = FIRST_SLOT;
    else if (tick && cycling) slot_nx = slot + 1'b1;
    else                      slot_nx = slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SLEEP;
      slot   <= FIRST_SLOT;
      gcnt   <= '0;
      oc_run <= '0;
    end else begin
      st   <= st_nx;
      slot <= slot_nx;
      if (tick && !short_hit) gcnt <= gcnt_nx;
      if (tick) begin
        if (any_over && charger_on) oc_run <= (oc_run == 2'd3) ? oc_run : oc_run + 1'b1;
        else                        oc_run <= '0;
      end
    end
  end

  assign switch_on  = (st == ST_RUN) || (st == ST_GRACE) ||
                      (st == ST_CYC_HI && slot != LAST_SLOT) ||
                      (st == ST_CYC_LO && slot == FIRST_SLOT);
  assign bleed_hi   = (st == ST_HOLD) && cell_hi_over;
  assign bleed_lo   = (st == ST_HOLD) && cell_lo_over;
  assign sleep_mode = (st == ST_SLEEP);

endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pack_low,
  input logic charger_on,
  input logic short_hit,
  input logic tap_lost,
  input logic switch_on,
  input logic bleed_hi,
  input logic bleed_lo,
  input logic sleep_mode
);

  assert_trip_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    short_hit |=> !switch_on);

  assert_tap_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tap_lost && !pack_low && !short_hit) |=> !switch_on);

  assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |-> !switch_on);

  assert_sleep_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode && !charger_on && !short_hit) |=> sleep_mode);

  assert_bleed_only_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bleed_hi || bleed_lo) |-> !switch_on);

  assert_quiet_between_ticks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !short_hit) |=> ($stable(switch_on) && $stable(sleep_mode)));

endmodule

bind pack_guard pack_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pack_low(pack_low),
  .charger_on(charger_on), .short_hit(short_hit), .tap_lost(tap_lost),
  .switch_on(switch_on), .bleed_hi(bleed_hi), .bleed_lo(bleed_lo),
  .sleep_mode(sleep_mode)
);

// File: tb/pack_guard_tb.sv
module pack_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 16;
  localparam int K_SLP = 0, K_RUN = 1, K_OPN = 2, K_GRC = 3,
                 K_HLD = 4, K_TRP = 5, K_C7 = 6, K_C1 = 7;

  logic clk = 0, rst_n = 0;
  logic tk = 0, hov = 0, lov = 0, hud = 0, lud = 0, uv = 0, chg = 0, ld = 0, sh = 0, tap = 0;
  logic [GW-1:0] gr = '0;
  logic sw, bh, bl, sl;

  int checks = 0, fails = 0;
  int m_md, m_ph, m_gc, m_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  pack_guard #(.GRACE_W(GW), .FRAME_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tk), .cell_hi_over(hov), .cell_lo_over(lov),
    .cell_hi_under(hud), .cell_lo_under(lud), .pack_low(uv), .charger_on(chg),
    .load_on(ld), .short_hit(sh), .tap_lost(tap), .grace_len(gr),
    .switch_on(sw), .bleed_hi(bh), .bleed_lo(bl), .sleep_mode(sl));

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {sw,bh,bl,sleep} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_out();
    logic s;
    s = (m_md == K_RUN) || (m_md == K_GRC) || (m_md == K_C7 && m_ph != 7) ||
        (m_md == K_C1 && m_ph == 0);
    return {s, (m_md == K_HLD) && hov, (m_md == K_HLD) && lov, m_md == K_SLP};
  endfunction

  function automatic string mode_tag();
    case (m_md)
      K_SLP: return "R8";
      K_RUN: return "R13";
      K_OPN: return "R3";
      K_GRC: return "R10";
      K_HLD: return "R11";
      K_TRP: return "R2";
      K_C7:  return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic model_edge();
    int cur = m_md, cl, nxt, ngc = m_gc;
    bit ov = hov | lov, ud = hud | lud;
    bit cyc = (cur == K_C7) || (cur == K_C1);
    bit ce = (cyc && m_ph != 7) ? 1'b1 : chg;
    if (tap) cl = (uv && ce) ? K_C1 : K_OPN;
    else if (uv) cl = ce ? K_C1 : K_SLP;
    else if (ud) cl = ce ? K_C7 : K_SLP;
    else if (ov) begin
      if (!ce) cl = ld ? K_RUN : K_OPN;
      else if (cur == K_HLD) cl = K_HLD;
      else if (cur == K_GRC) begin
        if (m_gc == 0) cl = K_HLD; else begin cl = K_GRC; ngc = m_gc - 1; end
      end else if (m_run >= 2 && chg) begin
        if (gr == 0) cl = K_HLD; else begin cl = K_GRC; ngc = int'(gr) - 1; end
      end else cl = K_RUN;
    end else cl = K_RUN;
    nxt = cur;
    if (sh) nxt = K_TRP;
    else if (tk) begin
      if (cur == K_TRP) nxt = ld ? K_TRP : cl;
      else if (cur == K_SLP && !chg) nxt = K_SLP;
      else nxt = cl;
    end
    if (tk && !sh) m_gc = ngc;
    if (tk) m_run = (ov && chg) ? ((m_run < 3) ? m_run + 1 : 3) : 0;
    if (nxt != cur) m_ph = 0;
    else if (tk && cyc) m_ph = (m_ph + 1) % 8;
    m_md = nxt;
  endtask

  task automatic cyc(bit t);
    tk = t;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(mode_tag(), {sw, bh, bl, sl}, model_out());
    tk = 0;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1); cyc(0); cyc(0); cyc(0);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_md = K_SLP; m_ph = 0; m_gc = 0; m_run = 0;
    repeat (3) @(negedge clk);
    chk("R1", {sw, bh, bl, sl}, 4'b0001);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {sw, bh, bl, sl}, 4'b0001);

    // R8: sleep ignores everything but the charger
    ld = 1; tick_n(2);
    chk("R8", {sw, bh, bl, sl}, 4'b0001);
    hud = 1; tick_n(1); hud = 0;
    chk("R8", {sw, bh, bl, sl}, 4'b0001);
    chg = 1; tick_n(1);
    chk("R8", {sw, bh, bl, sl}, 4'b1000);

    // R9 / R10 / R11: overcharge qualification, grace 2
    gr = 2; hov = 1;
    tick_n(1); chk("R9", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R9", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R10", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R10", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R11", {sw, bh, bl, sl}, 4'b0100);
    hov = 0; tick_n(1); chk("R11", {sw, bh, bl, sl}, 4'b1000);

    // R10: zero grace opens on the qualifying tick
    gr = 0; lov = 1;
    tick_n(2); chk("R10", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R10", {sw, bh, bl, sl}, 4'b0010);
    lov = 0; tick_n(1);

    // R12: overcharged without charger follows the load
    chg = 0; hov = 1; ld = 1;
    tick_n(1); chk("R12", {sw, bh, bl, sl}, 4'b1000);
    ld = 0; tick_n(1); chk("R12", {sw, bh, bl, sl}, 4'b0000);
    hov = 0; ld = 1; tick_n(1);

    // R7: over-discharge without charger sleeps
    lud = 1; tick_n(1); chk("R7", {sw, bh, bl, sl}, 4'b0001);
    chg = 1; tick_n(1); chk("R5", {sw, bh, bl, sl}, 4'b1000);

    // R5: 7-in-8 frame (now at slot 0)
    for (int s = 1; s < 7; s++) begin
      tick_n(1); chk("R5", {sw, bh, bl, sl}, 4'b1000);
    end
    tick_n(1); chk("R5", {sw, bh, bl, sl}, 4'b0000);
    tick_n(1); chk("R5", {sw, bh, bl, sl}, 4'b1000);
    // R6: charger ignored until the last slot
    chg = 0;
    tick_n(1); chk("R6", {sw, bh, bl, sl}, 4'b1000);
    tick_n(6); chk("R6", {sw, bh, bl, sl}, 4'b0000);
    tick_n(1); chk("R6", {sw, bh, bl, sl}, 4'b0001);
    lud = 0; chg = 1; tick_n(1);

    // R4: 1-in-8 frame under pack undervoltage
    uv = 1; tick_n(1); chk("R4", {sw, bh, bl, sl}, 4'b1000);
    tick_n(1); chk("R4", {sw, bh, bl, sl}, 4'b0000);
    uv = 0; tick_n(1);

    // R3: lost tap, with and without the undervoltage exception
    tap = 1; tick_n(1); chk("R3", {sw, bh, bl, sl}, 4'b0000);
    uv = 1; tick_n(1); chk("R3", {sw, bh, bl, sl}, 4'b1000);
    uv = 0; tick_n(1); chk("R3", {sw, bh, bl, sl}, 4'b0000);
    tap = 0; tick_n(1);

    // R2: short trip latches until load removed
    ld = 1; cyc(0); sh = 1; cyc(0);
    chk("R2", {sw, bh, bl, sl}, 4'b0000);
    sh = 0; tick_n(2); chk("R2", {sw, bh, bl, sl}, 4'b0000);
    ld = 0; tick_n(1); chk("R2", {sw, bh, bl, sl}, 4'b1000);

    // R13: flags between ticks have no effect
    hud = 1; tap = 1; cyc(0); cyc(0);
    chk("R13", {sw, bh, bl, sl}, 4'b1000);
    hud = 0; tap = 0; tick_n(1);
    chk("R13", {sw, bh, bl, sl}, 4'b1000);

    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 24000; i++) begin
      if ($urandom_range(0, 39) == 0) hov = ~hov;
      if ($urandom_range(0, 39) == 0) lov = ~lov;
      if ($urandom_range(0, 59) == 0) hud = ~hud;
      if ($urandom_range(0, 59) == 0) lud = ~lud;
      if ($urandom_range(0, 99) == 0) uv = ~uv;
      if ($urandom_range(0, 19) == 0) chg = ~chg;
      if ($urandom_range(0, 19) == 0) ld = ~ld;
      if ($urandom_range(0, 149) == 0) tap = ~tap;
      if ($urandom_range(0, 299) == 0) gr = GW'($urandom_range(0, 4));
      sh = ($urandom_range(0, 399) == 0);
      cyc($urandom_range(0, 3) == 0);
    end
    finish_run();
  end
endmodule